// File: doc/BRIEF.md
# Keyboard Controller Power-Down Sequencer

This block governs the clock enables of a small embedded keyboard-controller core across two low-power depths. When the core requests a halt, the block enters a light sleep in which only the execution-unit clock is gated. The timer and interrupt logic keep their clock, and the oscillator stays on. When the core requests a stop, the block enters a deep sleep that also drops the timer clock and switches the oscillator off.

The sequencer runs on an always-on reference clock, so it sees wake events while the core clock is gated. A wake event is either a controller reset request or a host write into the input data buffer. After a deep sleep, the block first re-enables the oscillator. It then waits until the oscillator reports ready for a programmable number of consecutive cycles, and only then releases the clocks.

On the first cycle of the returning execution clock, the block tells the core how to resume, using two flags:
- a one-cycle restart-at-address-zero flag when reset caused the wake;
- a one-cycle interrupt-call flag when a host write caused the wake and the buffer-full interrupt was enabled.

When neither flag is raised, the core simply continues with its next instruction.

Top module: `kbc_pwr_seq`

## Requirements
- R1: After `por_ni` is released, the block is in run state: `osc_en_o`, `tmr_clk_en_o` and `exu_clk_en_o` are high, and both resume flags are low.
- R2: A `halt_req_i` pulse in run state, with no wake in the same cycle, gives light sleep from the next cycle. In light sleep `exu_clk_en_o` is low while `tmr_clk_en_o` and `osc_en_o` stay high.
- R3: A `stop_req_i` pulse in run state, with no wake in the same cycle, gives deep sleep from the next cycle, with all three enables low. Stop takes precedence when halt and stop arrive together.
- R4: A wake in deep sleep raises only `osc_en_o` from the next cycle. The timer and execution enables return together, one cycle after the edge at which `osc_ready_i` has been high for SETTLE_CYC consecutive warm-up cycles. A low `osc_ready_i` restarts that count. The default of SETTLE_CYC is 4.
- R5: Only `core_rst_i` or `host_wr_i` ends a sleep. `ibf_ie_i`, `osc_ready_i`, `halt_req_i` and `stop_req_i` alone never do.
- R6: A host-write wake pulses `resume_irq_o` for exactly the first cycle of the returning execution clock when `ibf_ie_i` was high in the wake cycle. If `ibf_ie_i` was low, no flag is raised and the core continues with its next instruction.
- R7: A reset wake pulses `restart_zero_o` for exactly the first cycle of the returning execution clock. Reset wins over a host write in the same cycle. A reset arriving during oscillator warm-up replaces a pending host-write cause.
- R8: A halt or stop request that coincides with a wake in run state does not power down. The clocks stay on, and the resume flag for that wake's cause pulses in the next cycle.
- R9: Halt and stop requests outside run state are ignored. A reset or host write in run state without a request raises no flag.
- R10: The two resume flags are never high together, and either flag is high only while `exu_clk_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-running reference clock |
| por_ni | input | 1 | Asynchronous active-low reset of the sequencer |
| core_rst_i | input | 1 | Controller reset request; a wake source |
| host_wr_i | input | 1 | Strobe: host wrote the input data buffer; a wake source |
| halt_req_i | input | 1 | Core request to enter light sleep |
| stop_req_i | input | 1 | Core request to enter deep sleep |
| ibf_ie_i | input | 1 | Input-buffer-full interrupt enable |
| osc_ready_i | input | 1 | Oscillator reports stable output |
| osc_en_o | output | 1 | Oscillator enable |
| tmr_clk_en_o | output | 1 | Clock enable for timer/counter and interrupt logic |
| exu_clk_en_o | output | 1 | Clock enable for the execution unit |
| resume_irq_o | output | 1 | One-cycle pulse: resume with an interrupt call |
| restart_zero_o | output | 1 | One-cycle pulse: restart fetching at address 0 |

## Verification
The critical overlaps are a sleep request landing in the same cycle as a wake, and a reset landing in the same cycle as a host write.
- In the first case, the bench raises halt together with a host write in run state. It expects the clocks to stay on and an interrupt flag on the next cycle, with no sleep entered.
- In the second case, the bench raises reset and a host write together in light sleep. It also sends a reset into the warm-up window of a deep sleep that a host write began.

In both reset cases only the restart flag may appear. A behavioural reference model predicts each output on every cycle, so any drift in entry, exit or flag choice is caught at the cycle where it occurs.

// File: rtl/kbc_pwr_pkg.sv
package kbc_pwr_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIGHT = 2'd1,
    ST_DEEP  = 2'd2,
    ST_WARM  = 2'd3
  } pd_state_e;

  typedef struct packed {
    logic restart;
    logic irq;
  } resume_t;

  typedef struct packed {
    logic osc;
    logic tmr;
    logic exu;
  } clk_en_t;

  // Clock enables for each sleep state.
  function automatic clk_en_t enables_for(input pd_state_e st);
    clk_en_t en;
    case (st)
      ST_RUN:   en = '{osc: 1'b1, tmr: 1'b1, exu: 1'b1};
      ST_LIGHT: en = '{osc: 1'b1, tmr: 1'b1, exu: 1'b0};
      ST_WARM:  en = '{osc: 1'b1, tmr: 1'b0, exu: 1'b0};
      default:  en = '{osc: 1'b0, tmr: 1'b0, exu: 1'b0};
    endcase
    return en;
  endfunction

  // Resume kind for a wake: reset wins over a host write.
  function automatic resume_t classify_wake(input logic rst, input logic wr,
                                            input logic ie);
    resume_t r;
    r.restart = rst;
    r.irq     = !rst && wr && ie;
    return r;
  endfunction

  // A later reset overrides a pending host-write resume.
  function automatic resume_t merge_pending(input resume_t pend,
                                            input resume_t fresh,
                                            input logic rst_hit);
    return rst_hit ? fresh : pend;
  endfunction

endpackage

// File: rtl/kbc_wake_dec.sv
module kbc_wake_dec
  import kbc_pwr_pkg::*;
(
  input  logic    core_rst_i,
  input  logic    host_wr_i,
  input  logic    ibf_ie_i,
  output logic    wake_o,
  output logic    rst_hit_o,
  output resume_t kind_o
);

  assign wake_o    = core_rst_i | host_wr_i;
  assign rst_hit_o = core_rst_i;
  assign kind_o    = classify_wake(core_rst_i, host_wr_i, ibf_ie_i);

endmodule

// File: rtl/kbc_osc_settle.sv
module kbc_osc_settle #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic warm_i,
  input  logic osc_ready_i,
  output logic settled_o
);

  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign settled_o = warm_i && osc_ready_i && at_last;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cnt_q <= '0;
    end else if (!warm_i || !osc_ready_i) begin
      cnt_q <= '0;
    end else if (!at_last) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/kbc_pd_fsm.sv
module kbc_pd_fsm
  import kbc_pwr_pkg::*;
(
  input  logic    clk_i,
  input  logic    por_ni,
  input  logic    halt_req_i,
  input  logic    stop_req_i,
  input  logic    wake_i,
  input  logic    rst_hit_i,
  input  resume_t kind_i,
  input  logic    settled_i,
  output logic    warm_o,
  output clk_en_t en_o,
  output resume_t pulse_o
);

  pd_state_e state_q, state_d;
  resume_t   pend_q, pend_d, merged;
  resume_t   pulse_q, pulse_d;
  logic      enter_req;

  assign enter_req = halt_req_i | stop_req_i;
  assign merged    = merge_pending(pend_q, kind_i, rst_hit_i);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    pulse_d = '0;
    case (state_q)
      ST_RUN: begin
        if (enter_req) begin
          if (wake_i) pulse_d = kind_i;
          else        state_d = stop_req_i ? ST_DEEP : ST_LIGHT;
        end
      end
      ST_LIGHT: begin
        if (wake_i) begin
          state_d = ST_RUN;
          pulse_d = kind_i;
        end
      end
      ST_DEEP: begin
        if (wake_i) begin
          state_d = ST_WARM;
          pend_d  = kind_i;
        end
      end
      ST_WARM: begin
        pend_d = merged;
        if (settled_i) begin
          state_d = ST_RUN;
          pulse_d = merged;
          pend_d  = '0;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      state_q <= ST_RUN;
      pend_q  <= '0;
      pulse_q <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign warm_o  = (state_q == ST_WARM);
  assign en_o    = enables_for(state_q);
  assign pulse_o = pulse_q;

endmodule

// File: rtl/kbc_pwr_seq.sv
module kbc_pwr_seq
  import kbc_pwr_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic por_ni,
  input  logic core_rst_i,
  input  logic host_wr_i,
  input  logic halt_req_i,
  input  logic stop_req_i,
  input  logic ibf_ie_i,
  input  logic osc_ready_i,
  output logic osc_en_o,
  output logic tmr_clk_en_o,
  output logic exu_clk_en_o,
  output logic resume_irq_o,
  output logic restart_zero_o
);

  logic    wake_w;
  logic    rst_hit_w;
  resume_t kind_w;
  logic    warm_w;
  logic    settled_w;
  clk_en_t en_w;
  resume_t pulse_w;

  kbc_wake_dec u_wake (
    .core_rst_i (core_rst_i),
    .host_wr_i  (host_wr_i),
    .ibf_ie_i   (ibf_ie_i),
    .wake_o     (wake_w),
    .rst_hit_o  (rst_hit_w),
    .kind_o     (kind_w)
  );

  kbc_osc_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .warm_i      (warm_w),
    .osc_ready_i (osc_ready_i),
    .settled_o   (settled_w)
  );

  kbc_pd_fsm u_fsm (
    .clk_i      (clk_i),
    .por_ni     (por_ni),
    .halt_req_i (halt_req_i),
    .stop_req_i (stop_req_i),
    .wake_i     (wake_w),
    .rst_hit_i  (rst_hit_w),
    .kind_i     (kind_w),
    .settled_i  (settled_w),
    .warm_o     (warm_w),
    .en_o       (en_w),
    .pulse_o    (pulse_w)
  );

  assign osc_en_o       = en_w.osc;
  assign tmr_clk_en_o   = en_w.tmr;
  assign exu_clk_en_o   = en_w.exu;
  assign resume_irq_o   = pulse_w.irq;
  assign restart_zero_o = pulse_w.restart;

endmodule

// File: rtl/kbc_pwr_seq_chk.sv
module kbc_pwr_seq_chk (
  input logic clk_i,
  input logic por_ni,
  input logic core_rst_i,
  input logic host_wr_i,
  input logic halt_req_i,
  input logic stop_req_i,
  input logic ibf_ie_i,
  input logic osc_ready_i,
  input logic osc_en_o,
  input logic tmr_clk_en_o,
  input logic exu_clk_en_o,
  input logic resume_irq_o,
  input logic restart_zero_o
);

  logic in_light, in_warm, wake;
  assign in_light = !exu_clk_en_o && tmr_clk_en_o;
  assign in_warm  = osc_en_o && !tmr_clk_en_o;
  assign wake     = core_rst_i || host_wr_i;

  p_halt_enter_r2: assert property (@(posedge clk_i) disable iff (!por_ni)
    (exu_clk_en_o && halt_req_i && !stop_req_i && !wake)
      |=> (!exu_clk_en_o && tmr_clk_en_o && osc_en_o));

  p_stop_enter_r3: assert property (@(posedge clk_i) disable iff (!por_ni)
    (exu_clk_en_o && stop_req_i && !wake) |=> (!osc_en_o && !tmr_clk_en_o));

  p_warm_hold_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
    (in_warm && !osc_ready_i) |=> !exu_clk_en_o);

  p_tmr_needs_osc_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
    tmr_clk_en_o |-> osc_en_o);

  p_light_stays_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
    (in_light && !wake) |=> in_light);

  p_irq_call_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
    (in_light && host_wr_i && !core_rst_i && ibf_ie_i)
      |=> (resume_irq_o && exu_clk_en_o));

  p_next_insn_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
    (in_light && host_wr_i && !core_rst_i && !ibf_ie_i)
      |=> (!resume_irq_o && !restart_zero_o && exu_clk_en_o));

  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
    resume_irq_o |=> !resume_irq_o);

  p_reset_wins_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
    (in_light && core_rst_i) |=> (restart_zero_o && !resume_irq_o));

  p_coincide_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
    (exu_clk_en_o && (halt_req_i || stop_req_i) && wake) |=> exu_clk_en_o);

  p_flag_excl_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(resume_irq_o && restart_zero_o));

  p_flag_clock_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    (resume_irq_o || restart_zero_o) |-> exu_clk_en_o);

endmodule

bind kbc_pwr_seq kbc_pwr_seq_chk u_chk (
  .clk_i          (clk_i),
  .por_ni         (por_ni),
  .core_rst_i     (core_rst_i),
  .host_wr_i      (host_wr_i),
  .halt_req_i     (halt_req_i),
  .stop_req_i     (stop_req_i),
  .ibf_ie_i       (ibf_ie_i),
  .osc_ready_i    (osc_ready_i),
  .osc_en_o       (osc_en_o),
  .tmr_clk_en_o   (tmr_clk_en_o),
  .exu_clk_en_o   (exu_clk_en_o),
  .resume_irq_o   (resume_irq_o),
  .restart_zero_o (restart_zero_o)
);

// File: tb/kbc_pwr_seq_tb.sv
module kbc_pwr_seq_tb_top;

  localparam int SETTLE = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic core_rst = 1'b0, host_wr = 1'b0, halt = 1'b0, stop = 1'b0;
  logic ibf_ie = 1'b0, osc_rdy = 1'b1;
  logic osc_en, tmr_en, exu_en, r_irq, r_zero;

  int n_chk = 0, n_bad = 0;
  int seen_irq = 0, seen_zero = 0;
  bit done = 0;

  always #5 clk = ~clk;

  kbc_pwr_seq #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk_i(clk), .por_ni(por_n), .core_rst_i(core_rst), .host_wr_i(host_wr),
    .halt_req_i(halt), .stop_req_i(stop), .ibf_ie_i(ibf_ie),
    .osc_ready_i(osc_rdy), .osc_en_o(osc_en), .tmr_clk_en_o(tmr_en),
    .exu_clk_en_o(exu_en), .resume_irq_o(r_irq), .restart_zero_o(r_zero)
  );

  // Reference model: 0 run, 1 light, 2 deep off, 3 warm-up
  int m_mode = 0, m_cnt = 0;
  bit m_prst = 0, m_pirq = 0, m_irq = 0, m_zero = 0;

  always @(posedge clk) begin
    bit wk, ni, nr;
    wk = core_rst || host_wr;
    ni = 0; nr = 0;
    if (!por_n) begin
      m_mode = 0; m_cnt = 0; m_prst = 0; m_pirq = 0;
    end else begin
      case (m_mode)
        0: if (halt || stop) begin
             if (wk) begin nr = core_rst; ni = !core_rst && ibf_ie; end
             else m_mode = stop ? 2 : 1;
           end
        1: if (wk) begin m_mode = 0; nr = core_rst; ni = !core_rst && ibf_ie; end
        2: if (wk) begin
             m_mode = 3; m_cnt = 0;
             m_prst = core_rst; m_pirq = !core_rst && ibf_ie;
           end
        default: begin
          if (core_rst) begin m_prst = 1; m_pirq = 0; end
          if (osc_rdy) m_cnt++; else m_cnt = 0;
          if (m_cnt >= SETTLE) begin m_mode = 0; nr = m_prst; ni = m_pirq; end
        end
      endcase
    end
    m_irq = ni; m_zero = nr;
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (por_n && !done) begin
      string t;
      case (m_mode)
        0: t = "R1 run enables";
        1: t = "R2 light enables";
        2: t = "R3 deep enables";
        default: t = "R4 warm enables";
      endcase
      chk(t, osc_en, m_mode != 2);
      chk(t, tmr_en, m_mode <= 1);
      chk(t, exu_en, m_mode == 0);
      chk("R6 resume_irq", r_irq, m_irq);
      chk("R7 restart_zero", r_zero, m_zero);
      if (r_irq) seen_irq++;
      if (r_zero) seen_zero++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    por_n = 1'b1;
    idle(1);
    chk("R1 reset exu", exu_en, 1'b1);
    chk("R1 reset flags", r_irq | r_zero, 1'b0);

    // R2/R6: light sleep, host write with interrupt enabled
    halt = 1; idle(1); halt = 0; idle(3);
    ibf_ie = 0; idle(1); ibf_ie = 1; idle(1);   // R5: enable alone no wake
    host_wr = 1; idle(1); host_wr = 0; idle(3);

    // R6: host write with interrupt disabled -> next instruction
    halt = 1; idle(1); halt = 0; ibf_ie = 0; idle(2);
    host_wr = 1; idle(1); host_wr = 0; idle(3);

    // R7: reset and host write together in light sleep
    halt = 1; idle(1); halt = 0; ibf_ie = 1; idle(2);
    stop = 1; idle(1); stop = 0; idle(1);        // R9: ignored while asleep
    core_rst = 1; host_wr = 1; idle(1); core_rst = 0; host_wr = 0; idle(3);

    // R3/R4: halt+stop together -> deep; ready glitch restarts count
    halt = 1; stop = 1; idle(1); halt = 0; stop = 0; osc_rdy = 0; idle(4);
    chk("R3 deep osc off", osc_en, 1'b0);
    host_wr = 1; idle(1); host_wr = 0; idle(3);
    osc_rdy = 1; idle(2); osc_rdy = 0; idle(1); osc_rdy = 1; idle(8);

    // R7: reset wake from deep
    stop = 1; idle(1); stop = 0; osc_rdy = 0; idle(3);
    core_rst = 1; idle(1); core_rst = 0; idle(1); osc_rdy = 1; idle(8);

    // R7: reset during warm-up overrides pending host cause
    stop = 1; idle(1); stop = 0; idle(2);
    host_wr = 1; idle(1); host_wr = 0; idle(1);
    core_rst = 1; idle(1); core_rst = 0; idle(8);

    // R8: halt coinciding with host write in run state
    halt = 1; host_wr = 1; idle(1); halt = 0; host_wr = 0; idle(3);
    chk("R8 no sleep", exu_en, 1'b1);

    // R9: wake sources in run without a request raise no flag
    core_rst = 1; idle(1); core_rst = 0; host_wr = 1; idle(1); host_wr = 0; idle(3);

    chk("R6 irq pulse count", seen_irq == 3, 1'b1);
    chk("R7 restart pulse count", seen_zero == 3, 1'b1);
    chk("R10 ends in run", exu_en, 1'b1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule